// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block looks at a table of priority slots and picks, for each of two interrupt classes, the source that should be served first. Every slot points at one interrupt source, so software decides the ranking by filling the table. A separate steering vector splits the sources into a fast class and a normal class. A third vector says which sources are both enabled and pending; it is called the active vector here.

The block resolves each class on its own. It then packs both results into one 32-bit status word, which software or a vectoring unit reads to learn which source to serve next. The table storage and the register interface live outside the block and arrive as flat input vectors. The status word is registered, so it follows a change at the inputs after one clock edge.

Top module: `prio_resolver`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, the status word reads 32'h003F003F.
- R2: A 32-bit slot takes part only if its bit 31 is set and its bits 5:0 hold a source number below NUM_SRC (40). Bits 30:6 of a slot have no effect.
- R3: When several taking-part slots hold candidates of the same class, the slot with the smallest index wins. Slot 0 beats every other slot.
- R4: A taking-part slot is a fast candidate when its source has both its active bit and its steering bit at 1. It is a normal candidate when the active bit is 1 and the steering bit is 0. An inactive source is a candidate of neither class.
- R5: The fast winner's source number appears in status bits 5:0, and bit 15 is set.
- R6: The normal winner's source number appears in status bits 21:16, and bit 31 is set.
- R7: A class with no candidate has its flag bit at 0 and its number field at 6'h3F. With no candidate in either class, the word is 32'h003F003F.
- R8: Status bits 30:22 and 14:6 always read 0.
- R9: Several slots may name the same source. The smallest such slot decides the result, and nothing else changes.
- R10: The two classes are resolved independently. A fast winner in a high-priority slot does not hide a normal candidate in a lower-priority slot, and the reverse also holds.
- R11: The status word changes only at a rising clock edge. It reflects the inputs that were present just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tbl | input | NUM_SRC*32 | Slot k in bits [32k+31:32k]: bit 31 is the valid flag, bits 5:0 the source number |
| act_vec | input | NUM_SRC | Per-source enabled-and-pending bits |
| fast_sel | input | NUM_SRC | Per-source steering: 1 is fast class, 0 is normal class |
| status_word | output | 32 | Packed winners: {nrm_valid, 9'b0, nrm_id, fast_valid, 9'b0, fast_id} |

## Verification
The bench targets the cases where a resolver typically goes wrong.
- **Priority direction (R3).** A reversed table checks that slot index, not source number, sets priority; a design that ranks by source number would report the wrong source.
- **Slot qualification (R2).** Out-of-range numbers (40 to 47), slots without the valid flag, and junk in bits 30:6 probe whether a slot takes part; a design that indexes past the source vector or skips the flag would report a phantom winner.
- **Duplicates and class independence (R9, R10).** Duplicate slots and mixed-class tables check that the two classes are resolved separately; a single shared encoder would drop the normal winner whenever a fast one sits higher.
- **Random coverage.** A long random run compares every word against an independent model, including the empty-class number 6'h3F and the zero fields.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int ID_W           = 6;
    localparam int SLOT_W         = 32;
    localparam int SLOT_VALID_BIT = 31;
    localparam int STATUS_W       = 32;
    localparam int PAD_W          = 9;

    localparam logic [ID_W-1:0] EMPTY_ID = '1;

    typedef enum logic {
        CLS_FAST = 1'b0,
        CLS_NORM = 1'b1
    } irq_class_e;

    localparam int NUM_CLASSES = 2;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } class_win_t;

    typedef struct packed {
        logic             norm_valid;
        logic [PAD_W-1:0] norm_pad;
        logic [ID_W-1:0]  norm_id;
        logic             fast_valid;
        logic [PAD_W-1:0] fast_pad;
        logic [ID_W-1:0]  fast_id;
    } status_t;

    localparam class_win_t NO_WINNER = '{valid: 1'b0, id: EMPTY_ID};

    function automatic logic [ID_W-1:0] slot_source(input logic [SLOT_W-1:0] slot);
        return slot[ID_W-1:0];
    endfunction

    function automatic logic slot_flagged(input logic [SLOT_W-1:0] slot);
        return slot[SLOT_VALID_BIT];
    endfunction

    function automatic status_t pack_status(input class_win_t fast_w,
                                            input class_win_t norm_w);
        status_t s;
        s.norm_valid = norm_w.valid;
        s.norm_pad   = '0;
        s.norm_id    = norm_w.valid ? norm_w.id : EMPTY_ID;
        s.fast_valid = fast_w.valid;
        s.fast_pad   = '0;
        s.fast_id    = fast_w.valid ? fast_w.id : EMPTY_ID;
        return s;
    endfunction

    localparam status_t RESET_STATUS = '{
        norm_valid: 1'b0, norm_pad: '0, norm_id: EMPTY_ID,
        fast_valid: 1'b0, fast_pad: '0, fast_id: EMPTY_ID
    };

endpackage

// File: rtl/prio_slot_decode.sv
module prio_slot_decode
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC*SLOT_W-1:0] slot_tbl,
    input  logic [NUM_SRC-1:0]        act_vec,
    input  logic [NUM_SRC-1:0]        fast_sel,
    output logic [NUM_SRC-1:0]        fast_cand,
    output logic [NUM_SRC-1:0]        norm_cand,
    output logic [NUM_SRC*ID_W-1:0]   slot_ids
);

    localparam int IDX_SPAN = 1 << ID_W;
    localparam logic [ID_W:0] SRC_LIMIT = (ID_W+1)'(NUM_SRC);

    logic [IDX_SPAN-1:0] act_pad;
    logic [IDX_SPAN-1:0] fast_pad;

    assign act_pad  = IDX_SPAN'(act_vec);
    assign fast_pad = IDX_SPAN'(fast_sel);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
        logic [SLOT_W-1:0] word;
        logic [ID_W-1:0]   src;
        logic              in_range;
        logic              qual;
        logic              live;

        assign word     = slot_tbl[k*SLOT_W +: SLOT_W];
        assign src      = slot_source(word);
        assign in_range = ({1'b0, src} < SRC_LIMIT);
        assign qual     = slot_flagged(word) && in_range;
        assign live     = qual && act_pad[src];

        assign fast_cand[k] = live &&  fast_pad[src];
        assign norm_cand[k] = live && !fast_pad[src];
        assign slot_ids[k*ID_W +: ID_W] = src;
    end

endmodule

// File: rtl/prio_class_pick.sv
module prio_class_pick
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC-1:0]      cand,
    input  logic [NUM_SRC*ID_W-1:0] slot_ids,
    output class_win_t              win
);

    always_comb begin
        win = NO_WINNER;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (cand[k]) begin
                win.valid = 1'b1;
                win.id    = slot_ids[k*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/prio_status_reg.sv
module prio_status_reg
    import prio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  class_win_t fast_w,
    input  class_win_t norm_w,
    output status_t    status_q
);

    status_t status_d;

    assign status_d = pack_status(fast_w, norm_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= RESET_STATUS;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC*SLOT_W-1:0] slot_tbl,
    input  logic [NUM_SRC-1:0]        act_vec,
    input  logic [NUM_SRC-1:0]        fast_sel,
    output logic [STATUS_W-1:0]       status_word
);

    logic [NUM_CLASSES-1:0][NUM_SRC-1:0] cand_by_cls;
    logic [NUM_SRC*ID_W-1:0]             slot_ids;
    class_win_t [NUM_CLASSES-1:0]        win_by_cls;
    status_t                             status_q;

    prio_slot_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .slot_tbl  (slot_tbl),
        .act_vec   (act_vec),
        .fast_sel  (fast_sel),
        .fast_cand (cand_by_cls[CLS_FAST]),
        .norm_cand (cand_by_cls[CLS_NORM]),
        .slot_ids  (slot_ids)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        prio_class_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .cand     (cand_by_cls[c]),
            .slot_ids (slot_ids),
            .win      (win_by_cls[c])
        );
    end

    prio_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .fast_w   (win_by_cls[CLS_FAST]),
        .norm_w   (win_by_cls[CLS_NORM]),
        .status_q (status_q)
    );

    assign status_word = status_q;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC*SLOT_W-1:0] slot_tbl,
    input logic [NUM_SRC-1:0]        act_vec,
    input logic [NUM_SRC-1:0]        fast_sel,
    input logic [STATUS_W-1:0]       status_word
);

    localparam logic [ID_W-1:0] SRC_LIMIT = ID_W'(NUM_SRC);

    logic               rst_q;
    logic [NUM_SRC-1:0] act_q;
    logic [NUM_SRC-1:0] fast_q;
    logic [NUM_SRC-1:0] fast_onehot;
    logic [NUM_SRC-1:0] norm_onehot;
    logic               unused_tbl;

    assign unused_tbl = ^slot_tbl;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            act_q  <= '0;
            fast_q <= '0;
        end else begin
            act_q  <= act_vec;
            fast_q <= fast_sel;
        end
    end

    assign fast_onehot = NUM_SRC'(1) << status_word[5:0];
    assign norm_onehot = NUM_SRC'(1) << status_word[21:16];

    AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> status_word == 32'h003F003F);                            // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status_word[30:22] == '0 && status_word[14:6] == '0);              // R8
    AST_FAST_EMPTY_ID: assert property (@(posedge clk) disable iff (rst)
        !status_word[15] |-> status_word[5:0] == 6'h3F);                   // R7
    AST_NORM_EMPTY_ID: assert property (@(posedge clk) disable iff (rst)
        !status_word[31] |-> status_word[21:16] == 6'h3F);                 // R7
    AST_IDLE_WORD: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && act_q == '0) |-> status_word == 32'h003F003F);         // R7
    AST_FAST_WIN_LIVE: assert property (@(posedge clk) disable iff (rst)
        status_word[15] |-> (status_word[5:0] < SRC_LIMIT)
                            && |(fast_onehot & act_q & fast_q));           // R5
    AST_NORM_WIN_LIVE: assert property (@(posedge clk) disable iff (rst)
        status_word[31] |-> (status_word[21:16] < SRC_LIMIT)
                            && |(norm_onehot & act_q & ~fast_q));          // R6

endmodule

bind prio_resolver prio_resolver_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/tb_prio_resolver.sv
`timescale 1ns/1ps
module tb_prio_resolver;

    localparam int NS = 40;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NS*32-1:0] tbl = '0;
    logic [NS-1:0]    act = '0;
    logic [NS-1:0]    fs  = '0;
    logic [31:0]      status_word;

    int          checks   = 0;
    int          failures = 0;
    bit          finished = 1'b0;
    logic [31:0] last_exp = 32'h003F003F;
    sb_item_t    sb_q[$];

    always #2 clk = ~clk;

    prio_resolver #(.NUM_SRC(NS)) dut (
        .clk         (clk),
        .rst         (rst),
        .slot_tbl    (tbl),
        .act_vec     (act),
        .fast_sel    (fs),
        .status_word (status_word)
    );

    function automatic logic [31:0] model(input logic [NS*32-1:0] t,
                                          input logic [NS-1:0] a,
                                          input logic [NS-1:0] f);
        logic       fv = 1'b0;
        logic       nv = 1'b0;
        logic [5:0] fid = 6'h3F;
        logic [5:0] nid = 6'h3F;
        for (int s = 0; s < NS; s++) begin
            logic [31:0] w;
            int          src;
            w   = t[s*32 +: 32];
            src = int'(w[5:0]);
            if (w[31] && src < NS && a[src]) begin
                if (f[src] && !fv) begin fv = 1'b1; fid = w[5:0]; end
                if (!f[src] && !nv) begin nv = 1'b1; nid = w[5:0]; end
            end
        end
        return {nv, 9'b0, nid, fv, 9'b0, fid};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // driver: applies inputs at the falling edge, checks the word has not moved yet
    task automatic drive(input logic [NS*32-1:0] t, input logic [NS-1:0] a,
                         input logic [NS-1:0] f, input string tag);
        sb_item_t it;
        @(negedge clk);
        tbl = t; act = a; fs = f;
        it.exp = model(t, a, f);
        it.tag = tag;
        sb_q.push_back(it);
        #0.5;
        check("R11 hold before edge", status_word, last_exp);
        last_exp = it.exp;
    endtask

    // monitor: compares one result per clock edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, status_word, it.exp);
        end
    end

    function automatic logic [NS*32-1:0] ident_tbl();
        logic [NS*32-1:0] t = '0;
        for (int s = 0; s < NS; s++) t[s*32 +: 32] = 32'h8000_0000 | 32'(s);
        return t;
    endfunction

    function automatic logic [NS*32-1:0] rev_tbl();
        logic [NS*32-1:0] t = '0;
        for (int s = 0; s < NS; s++) t[s*32 +: 32] = 32'h8000_0000 | 32'(NS - 1 - s);
        return t;
    endfunction

    function automatic logic [NS-1:0] bit_of(input int n);
        return NS'(1) << n;
    endfunction

    initial begin
        logic [NS*32-1:0] t;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", status_word, 32'h003F003F);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", status_word, 32'h003F003F);

        drive('0, '0, '0, "R7 empty table");
        drive(ident_tbl(), '0, '1, "R7 no active source");
        drive(ident_tbl(), bit_of(5), '0, "R6 single normal");
        drive(ident_tbl(), bit_of(12), bit_of(12), "R5 single fast");
        drive(ident_tbl(), bit_of(3) | bit_of(20), '0, "R3 identity order");
        drive(rev_tbl(), bit_of(3) | bit_of(20), '0, "R3 reversed order");
        drive(rev_tbl(), bit_of(39) | bit_of(0), '1, "R3 fast reversed");
        drive(ident_tbl(), bit_of(7), '0, "R4 steer off is normal");
        drive(ident_tbl(), bit_of(7), bit_of(7), "R4 steer on is fast");
        drive(ident_tbl(), '0, bit_of(7), "R4 inactive is neither");

        t = '0;
        t[0*32 +: 32] = 32'h0000_0007;
        t[1*32 +: 32] = 32'h8000_0009;
        drive(t, bit_of(7) | bit_of(9), '0, "R2 flag clear skipped");
        t = '0;
        t[0*32 +: 32] = 32'h8000_002D;
        t[1*32 +: 32] = 32'h8000_0028;
        t[2*32 +: 32] = 32'h8000_0027;
        drive(t, '1, '0, "R2 out of range skipped");
        t = '0;
        t[0*32 +: 32] = 32'hFFFF_FFC4;
        drive(t, bit_of(4), bit_of(4), "R2 junk bits ignored");

        t = '0;
        t[0*32 +: 32] = 32'h8000_0004;
        t[1*32 +: 32] = 32'h8000_0004;
        t[2*32 +: 32] = 32'h8000_000A;
        drive(t, bit_of(4) | bit_of(10), bit_of(10), "R9 duplicate slots");
        t = '0;
        t[0*32 +: 32] = 32'h8000_0002;
        t[1*32 +: 32] = 32'h8000_0021;
        drive(t, bit_of(2) | bit_of(33), bit_of(2), "R10 fast above normal");
        drive(t, bit_of(2) | bit_of(33), bit_of(33), "R10 normal above fast");
        drive(ident_tbl(), '1, 40'h55_5555_5555, "R8 both classes full");

        for (int n = 0; n < 300; n++) begin
            logic [NS*32-1:0] rt;
            logic [NS-1:0]    ra;
            logic [NS-1:0]    rf;
            for (int s = 0; s < NS; s++) begin
                logic [31:0] w;
                w = {($urandom_range(0, 3) != 0), 25'($urandom), 6'($urandom_range(0, 47))};
                rt[s*32 +: 32] = w;
            end
            ra = {8'($urandom), 32'($urandom)} & {8'($urandom), 32'($urandom)}
                 & {8'($urandom), 32'($urandom)};
            rf = {8'($urandom), 32'($urandom)};
            drive(rt, ra, rf, "R3 R4 R10 random");
        end

        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        check("R8 pad fields", status_word & 32'h7FC0_7FC0, 32'h0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule